// File: doc/BRIEF.md
# Serial Sector CRC Generator and Checker

This block keeps a 16-bit cyclic redundancy check over the bit-serial data of one disc sector field. It sits beside the write encoder and the read data separator and sees each data bit as it passes. The generator polynomial is x^16 + x^12 + x^5 + 1. Bits are taken most significant first. A `start` pulse presets the register to all ones at the head of each field.

In write mode the data bits are folded into the register as they go out. A `field_end` pulse after the last data bit turns the block into a 16-bit shifter. It offers the check value on an output stream, high byte first and most significant bit first, and fills zeros in behind. In read mode the separated data bits are followed by the two recorded check bytes through the same register. At `field_end` the block tests for a zero residue. A nonzero residue sets a sticky error flag, which the processor reads after the field.

Both bit streams use valid/ready. An input bit is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while check bits are being shifted out. An output bit is consumed in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_bit` are held. There is no limit on how long the consumer may stall.

Top module: `sector_crc_unit`

## Requirements
- R1: After reset, or in the cycle after `start`, the register holds 16'hFFFF, `crc_err` is 0 and `out_valid` is 0. `start` overrides a `field_end` in the same cycle.
- R2: Each accepted input bit b updates the register c to {c[14:0],0} XOR (16'h1021 if c[15]^b else 0). In write mode, `field_end` causes the 16 register bits to be emitted on `out_bit`, MSB first. For the ASCII string "123456789" the emitted value is 16'h29B1.
- R3: While check bits are being emitted, `in_ready` is 0 and `in_valid` has no effect on the register.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays unchanged in the next cycle.
- R5: Exactly 16 output transfers follow a write-mode `field_end`, and then `out_valid` returns to 0. Each transfer shifts a zero into the register, so it holds 16'h0000 after the last one.
- R6: In read mode, `field_end` sets `crc_err` if the register is nonzero. `crc_err` stays set until the next `start`, whatever bits or `field_end` pulses follow.
- R7: In read mode, `field_end` never raises `out_valid`.
- R8: When `start` and an accepted input bit fall in the same cycle, the bit is folded into the preset value 16'hFFFF.
- R9: When `field_end` and an accepted input bit fall in the same cycle, the bit is folded first. The zero test in read mode, or the emission in write mode, then uses the updated register.
- R10: A `start` during emission ends it: `out_valid` is 0 and `in_ready` is 1 in the next cycle, and the register is preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Preset the register and clear the error flag |
| mode_wr | input | 1 | 1 = write (generate), 0 = read (check) |
| field_end | input | 1 | End of field: emit check bits (write) or test residue (read) |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit can be accepted |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Check bit available |
| out_ready | input | 1 | Consumer takes the check bit |
| out_bit | output | 1 | Serial check bit, MSB first |
| crc_err | output | 1 | Sticky read check failure |

## Verification
Two pairs of functions can meet in a single cycle. The first is the preset and the fold of the first data bit. The second is the fold of the last bit and the end-of-field action, which is the residue test in read mode or the start of emission in write mode. The bench drives `start` or `field_end` on the same clock as an accepted bit. It then judges the result at the ports against its own bit-serial model. In read mode a correct field that ends this way must leave `crc_err` clear, which happens only if the last check bit was folded before the zero test. In write mode the emitted 16 bits must equal the model value that includes that bit.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
endpackage

// File: rtl/crc_lfsr_step.sv
// One bit-serial update of a left-shifting CRC register.
module crc_lfsr_step #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] cur,
  input  logic         bit_in,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1] ^ bit_in;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb & POLY[i];
    end else begin : g_upper
      assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc_emit_ctrl.sv
// Counts the check bits remaining to be shifted out.
module crc_emit_ctrl #(
  parameter int unsigned W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic advance,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(W);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (clr) begin
      remain_q <= '0;
    end else if (load && (remain_q == '0)) begin
      remain_q <= LOAD_VAL;
    end else if (advance && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign active = (remain_q != '0);
endmodule

// File: rtl/crc_err_flag.sv
// Sticky residue-failure flag.
module crc_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic test,
  input  logic residue_nz,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (clr) begin
      err <= 1'b0;
    end else if (test && residue_nz) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/sector_crc_unit.sv
module sector_crc_unit
  import crc_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY,
  parameter logic [W-1:0] PRESET = CRC_PRESET
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_wr,
  input  logic field_end,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic crc_err
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_base;
  logic [W-1:0] crc_stepped;
  logic [W-1:0] crc_folded;
  logic         emitting;
  logic         take_bit;
  logic         shift_out;
  logic         end_ok;

  assign in_ready  = !emitting;
  assign take_bit  = in_valid && in_ready;
  assign out_valid = emitting;
  assign out_bit   = crc_q[W-1];
  assign shift_out = emitting && out_ready && !start;
  assign end_ok    = field_end && !start;

  assign crc_base = start ? PRESET : crc_q;

  crc_lfsr_step #(.W(W), .POLY(POLY)) u_step (
    .cur    (crc_base),
    .bit_in (in_bit),
    .nxt    (crc_stepped)
  );

  assign crc_folded = take_bit ? crc_stepped : crc_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (shift_out) begin
      crc_q <= {crc_q[W-2:0], 1'b0};
    end else begin
      crc_q <= crc_folded;
    end
  end

  crc_emit_ctrl #(.W(W)) u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .load    (end_ok && mode_wr),
    .advance (out_ready),
    .active  (emitting)
  );

  crc_err_flag u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .test       (end_ok && !mode_wr),
    .residue_nz (crc_folded != '0),
    .err        (crc_err)
  );
endmodule

// File: rtl/sector_crc_unit_chk.sv
module sector_crc_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mode_wr,
  input logic field_end,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic crc_err
);
  localparam int unsigned CW = $clog2(W + 1) + 1;
  logic [CW-1:0] xfer_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_cnt <= '0;
    else if (start || !out_valid) xfer_cnt <= '0;
    else if (out_ready) xfer_cnt <= xfer_cnt + 1'b1;
  end

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!crc_err && !out_valid));

  p_no_input_while_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_bit)));

  p_emit_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (xfer_cnt < CW'(W)));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !start) |=> crc_err);

  p_read_no_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !mode_wr) |=> !out_valid);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start) |=> (in_ready && !out_valid));

  p_end_ignored_by_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && field_end && !out_valid) |=> !out_valid);
endmodule

bind sector_crc_unit sector_crc_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode_wr   (mode_wr),
  .field_end (field_end),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .crc_err   (crc_err)
);

// File: tb/sector_crc_unit_test.sv
module sector_crc_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_wr = 1'b1, field_end = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, crc_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sector_crc_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_wr(mode_wr),
    .field_end(field_end), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .crc_err(crc_err)
  );

  // {data word, corrupt-on-read flag}
  localparam logic [16:0] VEC [0:5] = '{
    {16'h0000, 1'b0}, {16'hFFFF, 1'b0}, {16'hA55A, 1'b1},
    {16'h1234, 1'b0}, {16'h8001, 1'b1}, {16'h00FF, 1'b0}
  };

  function automatic logic [15:0] fold(input logic [15:0] c, input logic b);
    fold = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [15:0] fold_word(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) r = fold(r, w[i]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic fe, input logic v, input logic b);
    start = s; field_end = fe; in_valid = v; in_bit = b;
    @(negedge clk);
    start = 0; field_end = 0; in_valid = 0; in_bit = 0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int nb, input logic fe_last);
    for (int i = nb - 1; i >= 0; i--) cyc(1'b0, fe_last && (i == 0), 1'b1, w[i]);
  endtask

  task automatic collect(output logic [15:0] w);
    w = '0;
    out_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      w = {w[14:0], out_valid ? out_bit : 1'bx};
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [15:0] got, exp, c;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 reset in_ready", {15'd0, in_ready}, 16'd1);
    chk("R1 reset crc_err", {15'd0, crc_err}, 16'd0);

    // R1 preset value via empty field
    mode_wr = 1'b1;
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    collect(got);
    chk("R1 preset emitted", got, 16'hFFFF);

    // Vector table: write then read per entry (R2, R6)
    for (int k = 0; k < 6; k++) begin
      logic [15:0] d;
      logic bad;
      d = VEC[k][16:1]; bad = VEC[k][0];
      exp = fold_word(16'hFFFF, d);
      mode_wr = 1'b1;
      cyc(1, 0, 0, 0);
      send_bits(d, 16, 1'b0);
      cyc(0, 1, 0, 0);
      collect(got);
      chk("R2 vector write crc", got, exp);
      mode_wr = 1'b0;
      cyc(1, 0, 0, 0);
      send_bits(bad ? (d ^ 16'h0008) : d, 16, 1'b0);
      send_bits(exp, 16, 1'b0);
      cyc(0, 1, 0, 0);
      chk("R6 vector read err", {15'd0, crc_err}, {15'd0, bad});
    end

    // R2 anchor "123456789" -> 29B1
    mode_wr = 1'b1;
    cyc(1, 0, 0, 0);
    send_bits(16'h3132, 16, 0); send_bits(16'h3334, 16, 0);
    send_bits(16'h3536, 16, 0); send_bits(16'h3738, 16, 0);
    send_bits(16'h0039, 8, 0);
    cyc(0, 1, 0, 0);
    collect(got);
    chk("R2 known string", got, 16'h29B1);

    // R4 stall, R3 ignored input, R5 length and zero fill
    cyc(1, 0, 0, 0);
    send_bits(16'hC3A5, 16, 0);
    exp = fold_word(16'hFFFF, 16'hC3A5);
    cyc(0, 1, 0, 0);
    held = {15'd0, out_bit};
    for (int i = 0; i < 3; i++) begin
      chk("R3 in_ready low while emitting", {15'd0, in_ready}, 16'd0);
      cyc(0, 0, 1, 1'b1);
      chk("R4 out_valid held on stall", {15'd0, out_valid}, 16'd1);
      chk("R4 out_bit held on stall", {15'd0, out_bit}, held);
    end
    collect(got);
    chk("R3 emitted value unaffected by in_valid", got, exp);
    chk("R5 out_valid low after 16", {15'd0, out_valid}, 16'd0);
    cyc(0, 1, 0, 0);
    collect(got);
    chk("R5 register zero after shift-out", got, 16'h0000);

    // R8 start with first bit
    cyc(1, 0, 1, 1'b1);
    cyc(0, 1, 0, 0);
    collect(got);
    chk("R8 start plus bit", got, fold(16'hFFFF, 1'b1));

    // R9 write: last bit with field_end
    cyc(1, 0, 0, 0);
    send_bits(16'h5A0F, 16, 1'b1);
    collect(got);
    chk("R9 write last bit folded", got, fold_word(16'hFFFF, 16'h5A0F));

    // R9 read: final check bit with field_end, no error expected
    mode_wr = 1'b0;
    c = fold_word(16'hFFFF, 16'h9E37);
    cyc(1, 0, 0, 0);
    send_bits(16'h9E37, 16, 0);
    send_bits(c, 16, 1'b1);
    chk("R9 read last bit folded before test", {15'd0, crc_err}, 16'd0);

    // R7 read field_end does not emit
    cyc(0, 1, 0, 0);
    chk("R7 no emission in read", {15'd0, out_valid}, 16'd0);

    // R6 sticky: make an error, then more bits and a clean-looking end
    cyc(1, 0, 0, 0);
    send_bits(16'h0001, 16, 1'b1);
    chk("R6 error set", {15'd0, crc_err}, 16'd1);
    send_bits(16'h0000, 16, 1'b0);
    cyc(0, 1, 0, 0);
    chk("R6 error sticky", {15'd0, crc_err}, 16'd1);
    cyc(1, 0, 0, 0);
    chk("R1 start clears error", {15'd0, crc_err}, 16'd0);

    // R10 start aborts emission
    mode_wr = 1'b1;
    send_bits(16'h7777, 16, 1'b1);
    chk("R10 emitting before abort", {15'd0, out_valid}, 16'd1);
    cyc(1, 0, 0, 0);
    chk("R10 out_valid low after abort", {15'd0, out_valid}, 16'd0);
    chk("R10 in_ready high after abort", {15'd0, in_ready}, 16'd1);
    cyc(0, 1, 0, 0);
    collect(got);
    chk("R10 preset after abort", got, 16'hFFFF);

    // R1 start overrides field_end
    cyc(1, 1, 0, 0);
    chk("R1 start beats field_end", {15'd0, out_valid}, 16'd0);

    finished = 1'b1;
    summary();
  end
endmodule